// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is the serial-side controller of a small byte-addressed nonvolatile memory of 512 x 8 bits. It sits behind the four SPI pins (chip select, serial clock, serial in and serial out with an output enable) plus a pause pin. It works in SPI modes 0 and 3. All pins are sampled on a fast system clock, and edges of the serial clock are found by comparing each sample with the one before. The first byte after chip select falls is an instruction. Reads stream bytes out of a behavioural register array. Writes collect up to 16 bytes in a page buffer. A write is committed only when chip select rises on a byte boundary after a complete write sequence.

A companion block owns the status byte and the protection rules. This engine shows it the status byte through `stat_in`. It pulses `set_wel` and `clr_wel` for the write-enable instructions, and it hands over a written status byte on `stat_wr`/`stat_wdata`. It exposes the start address of the pending page write on `wr_addr`, and it needs `wr_permit` to be high when chip select rises before it starts a write. The self-timed internal write is modelled by a counter of `WR_CYCLES` clock cycles, shown on `busy`. The page is copied into the array in the last of those cycles.

The controller is a state machine with these states:
- ST_IDLE: chip select is high.
- ST_OPCODE: collecting the instruction.
- ST_ADDR: collecting the address byte.
- ST_RDATA: streaming array data.
- ST_WDATA: collecting page data.
- ST_SRRD: streaming the status byte.
- ST_SRWR: collecting a status byte.
- ST_DROP: ignoring the rest of the selection.

Its transitions are:
- ST_IDLE to ST_OPCODE when chip select falls.
- ST_OPCODE to ST_SRRD, ST_SRWR, ST_ADDR or ST_DROP on the eighth bit, chosen by the decoded instruction and by `busy`.
- ST_ADDR to ST_RDATA or ST_WDATA on the eighth bit.
- ST_SRWR to ST_DROP after its data byte.
- Any state to ST_IDLE whenever chip select is high.

Top module: `eep_spi_engine`

## Requirements
- R1: After reset, `so_oe` and `busy` are low and every array byte reads as 0x00.
- R2: Instruction `0000_A011` followed by one address byte reads from address {A, address byte}. Each data byte leaves on `so` MSB first, changing on serial clock falling edges, with `so_oe` high for the whole data phase. SI is sampled on rising edges, and modes 0 and 3 both work.
- R3: During a read the address advances after every byte and wraps from 0x1FF to 0x000.
- R4: Instruction `0000_A010` with an address byte and 1 to 16 data bytes, ended by chip select rising on a byte boundary, raises `busy` for exactly `WR_CYCLES` clock cycles. The bytes are in the array once `busy` falls.
- R5: During a write only the low 4 address bits advance, wrapping inside the 16-byte page, and a later byte replaces an earlier one at the same offset.
- R6: A write whose chip select rises mid-byte, or before any data byte, starts no internal write and leaves the array unchanged.
- R7: If `wr_permit` is low when chip select rises, the write is discarded.
- R8: While `busy` is high only 0x05 is accepted. Other instructions produce no pulse and no output.
- R9: Instruction 0x05 streams `stat_in` MSB first, repeating for every further byte.
- R10: Instruction 0x06 gives one single-cycle `set_wel` pulse. Instruction 0x04 gives one `clr_wel` pulse.
- R11: Instruction 0x01 passes the next byte to `stat_wdata` with a single-cycle `stat_wr` pulse.
- R12: Pulling `hold_n` low while the serial clock is low pauses the transfer. `so_oe` drops and clock edges are ignored. Raising `hold_n` while the clock is low resumes at the same bit.
- R13: Chip select high drops `so_oe` and aborts any sequence. An unknown instruction is ignored until the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| stat_in | input | 8 | Status byte from the companion block |
| wr_permit | input | 1 | Companion allows the pending page write |
| set_wel | output | 1 | Pulse: set write enable |
| clr_wel | output | 1 | Pulse: clear write enable |
| stat_wr | output | 1 | Pulse: status byte written |
| stat_wdata | output | 8 | Status byte written by the host |
| wr_addr | output | ADDR_W | Start address of the current page write |
| busy | output | 1 | Internal write in progress |

## Verification
The assertions take for granted that all pins are synchronous to `clk`. They also assume the serial clock stays at each level for several system clocks, so that every edge is seen exactly once, and that `hold_n` changes only while the serial clock is low. The bench drives every pin on the falling edge of `clk` and holds each serial clock phase for four system clocks. It changes `hold_n` only after a low phase has settled. It samples `so` just before each rising edge, which is where a host would. The bench sweeps every page of the array, alternating modes 0 and 3, and compares a full read against an arithmetic model.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SRRD,
        ST_SRWR,
        ST_DROP
    } eep_state_e;

    localparam logic [7:0] OP_SETWE = 8'h06;
    localparam logic [7:0] OP_CLRWE = 8'h04;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WRST  = 8'h01;
endpackage

// File: rtl/eep_pin_front.sv
module eep_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic paused
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            paused <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n)
                paused <= 1'b0;
            else if (!sck)
                paused <= !hold_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n & ~paused;
    assign sck_fall = ~sck & sck_q & ~cs_n & ~paused;
    assign cs_rise  = cs_n & ~cs_q;
    assign cs_fall  = ~cs_n & cs_q;

    // R12: a pause only ends while the serial clock is low
    a_r12_resume_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(paused) && !cs_n) |-> !$past(sck));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [PAGE_W-1:0]     idx,
    input  logic [7:0]            wd,
    output logic [(1<<PAGE_W)-1:0][7:0] data,
    output logic [(1<<PAGE_W)-1:0]      vld
);
    localparam int NB = 1 << PAGE_W;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[g] <= '0;
                vld[g]  <= 1'b0;
            end else if (clr) begin
                vld[g]  <= 1'b0;
            end else if (we && idx == PAGE_W'(g)) begin
                data[g] <= wd;
                vld[g]  <= 1'b1;
            end
        end
    end

    // R5: a stored byte is marked and holds the latest value for its offset
    a_r5_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vld[$past(idx)] && data[$past(idx)] == $past(wd)));
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R4: an internal write is never restarted while one runs
    a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R4: the cycle ends right after its commit cycle
    a_r4_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/eep_spi_engine.sv
module eep_spi_engine #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic [7:0]        stat_in,
    input  logic              wr_permit,
    output logic              set_wel,
    output logic              clr_wel,
    output logic              stat_wr,
    output logic [7:0]        stat_wdata,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy
);
    import eep_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = 1 << PAGE_W;

    eep_state_e st, st_nx;

    logic sck_rise, sck_fall, cs_rise, cs_fall, paused;
    logic [2:0] bitcnt;
    logic [6:0] shin;
    logic [7:0] rx_byte;
    logic       byte_done;
    logic       rd_mode, a_hi, got_data;
    logic [ADDR_W-1:0] ptr;
    logic [6:0] osh;
    logic       so_q;
    logic       is_rd, is_wr;
    logic [8:0] addr_full;
    logic [7:0] cur_byte;
    logic       wr_go, wr_done;
    logic       pb_clr, pb_we;
    logic [NB-1:0][7:0] pb_data;
    logic [NB-1:0]      pb_vld;
    logic [7:0] mem [DEPTH];

    eep_pin_front u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .paused(paused)
    );

    eep_page_buf #(.PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
        .idx(ptr[PAGE_W-1:0]), .wd(rx_byte), .data(pb_data), .vld(pb_vld)
    );

    eep_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(busy), .done(wr_done)
    );

    assign rx_byte   = {shin, si};
    assign byte_done = sck_rise && (bitcnt == 3'd7);
    assign is_rd     = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == 3'b011);
    assign is_wr     = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == 3'b010);
    assign addr_full = {a_hi, rx_byte};
    assign cur_byte  = (st == ST_SRRD) ? stat_in : mem[ptr];
    assign pb_clr    = (st == ST_ADDR) && byte_done && !rd_mode;
    assign pb_we     = (st == ST_WDATA) && byte_done;
    assign wr_go     = cs_rise && (st == ST_WDATA) && (bitcnt == 3'd0)
                       && got_data && wr_permit && !busy;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (cs_fall) st_nx = ST_OPCODE;
            ST_OPCODE: if (byte_done) begin
                if (busy)
                    st_nx = (rx_byte == OP_RDST) ? ST_SRRD : ST_DROP;
                else if (rx_byte == OP_RDST)
                    st_nx = ST_SRRD;
                else if (rx_byte == OP_WRST)
                    st_nx = ST_SRWR;
                else if (is_rd || is_wr)
                    st_nx = ST_ADDR;
                else
                    st_nx = ST_DROP;
            end
            ST_ADDR:   if (byte_done) st_nx = rd_mode ? ST_RDATA : ST_WDATA;
            ST_SRWR:   if (byte_done) st_nx = ST_DROP;
            ST_RDATA, ST_WDATA, ST_SRRD, ST_DROP: st_nx = st;
        endcase
        if (cs_n && st != ST_IDLE)
            st_nx = ST_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            shin       <= '0;
            rd_mode    <= 1'b0;
            a_hi       <= 1'b0;
            got_data   <= 1'b0;
            ptr        <= '0;
            osh        <= '0;
            so_q       <= 1'b0;
            set_wel    <= 1'b0;
            clr_wel    <= 1'b0;
            stat_wr    <= 1'b0;
            stat_wdata <= '0;
            wr_addr    <= '0;
        end else begin
            set_wel <= 1'b0;
            clr_wel <= 1'b0;
            stat_wr <= 1'b0;
            if (cs_n)
                bitcnt <= '0;
            else if (sck_rise) begin
                bitcnt <= bitcnt + 3'd1;
                shin   <= {shin[5:0], si};
            end
            if (st == ST_OPCODE && byte_done) begin
                rd_mode <= is_rd;
                a_hi    <= rx_byte[3];
                if (!busy) begin
                    set_wel <= (rx_byte == OP_SETWE);
                    clr_wel <= (rx_byte == OP_CLRWE);
                end
            end
            if (st == ST_ADDR && byte_done) begin
                ptr      <= addr_full[ADDR_W-1:0];
                got_data <= 1'b0;
                if (!rd_mode)
                    wr_addr <= addr_full[ADDR_W-1:0];
            end
            if (pb_we) begin
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                got_data        <= 1'b1;
            end
            if (st == ST_SRWR && byte_done) begin
                stat_wr    <= 1'b1;
                stat_wdata <= rx_byte;
            end
            if (sck_fall && (st == ST_RDATA || st == ST_SRRD)) begin
                if (bitcnt == 3'd0) begin
                    so_q <= cur_byte[7];
                    osh  <= cur_byte[6:0];
                end else begin
                    so_q <= osh[6];
                    osh  <= {osh[5:0], 1'b0};
                end
                if (st == ST_RDATA && bitcnt == 3'd7)
                    ptr <= ptr + ADDR_W'(1);
            end
        end
    end

    // array with page commit at the end of the internal write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_done) begin
            for (int i = 0; i < NB; i++)
                if (pb_vld[i])
                    mem[{wr_addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pb_data[i];
        end
    end

    assign so    = so_q;
    assign so_oe = (st == ST_RDATA || st == ST_SRRD) && !paused;

    // R13: output enable drops once chip select has risen
    a_r13_oe_off_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !so_oe);
    // R12: no bit is counted while paused
    a_r12_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cs_n) |=> $stable(bitcnt));
    // R10: enable pulses last one cycle
    a_r10_wel_single: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wel || clr_wel) |=> !(set_wel || clr_wel));
    // R8: no instruction side effect while the internal write runs
    a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(set_wel || clr_wel || stat_wr));
    // R5: write pointer stays inside its page
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        pb_we |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
    // R3: read pointer advances once per byte
    a_r3_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDATA && sck_fall && bitcnt == 3'd7) |=> ptr == $past(ptr) + ADDR_W'(1));
endmodule

// File: tb/eep_spi_engine_tb.sv
module eep_spi_engine_tb;
    localparam int WRC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    logic [7:0] stat_in = 8'hA5;
    logic wr_permit = 1'b1;
    logic set_wel, clr_wel, stat_wr, busy;
    logic [7:0] stat_wdata;
    logic [8:0] wr_addr;

    int checks = 0, errors = 0;
    int n_set = 0, n_clr = 0, n_stw = 0;
    logic [7:0] exp_mem [512];
    logic m3 = 1'b0;

    always #2 clk = ~clk;

    eep_spi_engine #(.ADDR_W(9), .PAGE_W(4), .WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .stat_in(stat_in), .wr_permit(wr_permit),
        .set_wel(set_wel), .clr_wel(clr_wel), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .wr_addr(wr_addr), .busy(busy)
    );

    always @(posedge clk) begin
        if (set_wel) n_set <= n_set + 1;
        if (clr_wel) n_clr <= n_clr + 1;
        if (stat_wr) n_stw <= n_stw + 1;
    end

    function automatic logic [7:0] pat(input int a, input int s);
        return 8'(a * 37 + s * 11 + 5);
    endfunction

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic sel();
        sck <= m3;
        nclk(2);
        cs_n <= 1'b0;
        nclk(4);
    endtask

    task automatic desel();
        if (!m3) begin
            sck <= 1'b0;
            nclk(4);
        end
        cs_n <= 1'b1;
        nclk(1);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb,
                         output logic [7:0] rx, output bit oe_all);
        rx = '0;
        oe_all = 1'b1;
        for (int i = 7; i >= 8 - nb; i--) begin
            sck <= 1'b0;
            si  <= tx[i];
            nclk(4);
            rx[i] = so;
            if (!so_oe) oe_all = 1'b0;
            sck <= 1'b1;
            nclk(4);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
        xbits(tx, 8, rx, oe_all);
    endtask

    task automatic do_write(input int addr, input int n, input int seed, input int tail);
        logic [7:0] r;
        bit o;
        sel();
        xbyte({4'h0, addr[8], 3'b010}, r, o);
        xbyte(addr[7:0], r, o);
        for (int k = 0; k < n; k++) xbyte(pat(addr + k, seed), r, o);
        if (tail > 0) xbits(8'h5A, tail, r, o);
        desel();
    endtask

    task automatic model_write(input int addr, input int n, input int seed);
        for (int k = 0; k < n; k++)
            exp_mem[(addr & 9'h1F0) | ((addr + k) & 15)] = pat(addr + k, seed);
    endtask

    task automatic do_read(input int addr, input int n, input string tag);
        logic [7:0] r;
        bit o;
        sel();
        xbyte({4'h0, addr[8], 3'b011}, r, o);
        xbyte(addr[7:0], r, o);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, r, o);
            chk(r == exp_mem[(addr + k) % 512] && o, tag, r, exp_mem[(addr + k) % 512]);
        end
        desel();
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin g++; nclk(1); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        bit o;
        int len, s0;
        for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
        nclk(5);
        rst_n <= 1'b1;
        nclk(3);

        // R1: reset state
        chk(!so_oe && !busy, "R1 idle outputs", {so_oe, busy}, 0);

        // R9: status stream repeats
        sel();
        xbyte(8'h05, r, o);
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, r, o);
            chk(r == 8'hA5 && o, "R9 status byte", r, 8'hA5);
        end
        desel();

        // R10: enable pulses
        s0 = n_set;
        sel(); xbyte(8'h06, r, o); desel();
        chk(n_set == s0 + 1, "R10 set pulse count", n_set - s0, 1);
        s0 = n_clr;
        sel(); xbyte(8'h04, r, o); desel();
        chk(n_clr == s0 + 1, "R10 clear pulse count", n_clr - s0, 1);

        // R11: status write
        s0 = n_stw;
        sel(); xbyte(8'h01, r, o); xbyte(8'h8C, r, o); desel();
        chk(n_stw == s0 + 1 && stat_wdata == 8'h8C, "R11 status write", stat_wdata, 8'h8C);

        // R1: array clear after reset
        do_read(0, 4, "R1 cleared array");

        // R4: sweep every page, alternating modes
        for (int p = 0; p < 32; p++) begin
            m3 = p[0];
            do_write(p * 16, 16, p, 0);
            model_write(p * 16, 16, p);
            len = 0;
            while (busy && len < 5000) begin len++; nclk(1); end
            chk(len == WRC, "R4 busy length", len, WRC);
        end
        m3 = 1'b0;
        // R2: full read in mode 0, R3: wrap read in mode 3
        do_read(0, 512, "R2 full read");
        m3 = 1'b1;
        do_read(9'h1F8, 16, "R3 wrap read");
        m3 = 1'b0;

        // R5: page wrap with overwrite
        do_write(9'h13E, 20, 77, 0);
        model_write(9'h13E, 20, 77);
        wait_idle();
        do_read(9'h130, 16, "R5 page wrap");

        // R6: chip select mid-byte and no data byte
        do_write(9'h050, 1, 3, 4);
        nclk(2);
        chk(!busy, "R6 mid-byte abort", busy, 0);
        do_write(9'h060, 0, 3, 0);
        nclk(2);
        chk(!busy, "R6 no data byte", busy, 0);
        do_read(9'h050, 32, "R6 array unchanged");

        // R7: companion denies the write
        wr_permit <= 1'b0;
        do_write(9'h070, 4, 9, 0);
        nclk(2);
        chk(!busy, "R7 denied write", busy, 0);
        wr_permit <= 1'b1;
        do_read(9'h070, 4, "R7 array unchanged");

        // R8: only status read while busy
        do_write(9'h0A0, 8, 21, 0);
        model_write(9'h0A0, 8, 21);
        sel(); xbyte(8'h05, r, o); xbyte(8'h00, r, o); desel();
        chk(r == 8'hA5 && o, "R8 status while busy", r, 8'hA5);
        s0 = n_set;
        sel(); xbyte(8'h06, r, o); desel();
        chk(n_set == s0, "R8 enable ignored", n_set - s0, 0);
        sel(); xbyte(8'h03, r, o); xbyte(8'h00, r, o); xbyte(8'h00, r, o); desel();
        chk(!o, "R8 read ignored oe", o, 0);
        chk(busy, "R8 still busy", busy, 1);
        wait_idle();
        do_read(9'h0A0, 8, "R8 write landed");

        // R12: pause mid-byte during read
        sel();
        xbyte(8'h0B, r, o);
        xbyte(8'h23, r, o);
        for (int i = 7; i >= 0; i--) begin
            sck <= 1'b0;
            nclk(4);
            if (i == 3) begin
                hold_n <= 1'b0;
                nclk(3);
                chk(!so_oe, "R12 oe off in pause", so_oe, 0);
                for (int t = 0; t < 2; t++) begin
                    sck <= 1'b1; nclk(4); sck <= 1'b0; nclk(4);
                end
                hold_n <= 1'b1;
                nclk(3);
            end
            r[i] = so;
            sck <= 1'b1;
            nclk(4);
        end
        chk(r == exp_mem[9'h123], "R12 byte after resume", r, exp_mem[9'h123]);
        xbyte(8'h00, r, o);
        chk(r == exp_mem[9'h124], "R12 next byte", r, exp_mem[9'h124]);
        desel();

        // R13: unknown instruction and abort
        s0 = n_set + n_clr + n_stw;
        sel(); xbyte(8'hFF, r, o); xbyte(8'h06, r, o); desel();
        chk(!o && (n_set + n_clr + n_stw) == s0, "R13 unknown ignored", o, 0);
        sel(); xbyte(8'h03, r, o); xbyte(8'h10, r, o); xbits(8'h00, 2, r, o);
        desel();
        nclk(1);
        chk(!so_oe, "R13 oe off after abort", so_oe, 0);
        do_read(9'h10, 2, "R13 fresh read");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule